// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recently used virtual-to-physical translations for a 32-bit address space. Each slot holds a mapping kind, a virtual tag, a physical base, a permission field and a 4-bit domain. The mapping kind sets how many low address bits are ignored when a slot is compared. A lookup compares the presented virtual address against every valid slot in parallel, each under its own kind's mask. The lowest-numbered matching slot supplies the result in the same cycle.

A table walker writes new translations through the fill port. A round-robin pointer picks the slot that a fill replaces. Two maintenance operations exist: flush-all drops every translation and rewinds the pointer, and flush-by-address drops the one translation that a lookup of that address would return. The walker, permission checking and memory access sit outside the block.

Top module: `xlt_cache`

## Requirements
- R1: After a synchronous active-high reset, every slot is invalid, so every lookup misses, and the first fill lands in slot 0.
- R2: The mapping kind is a 3-bit code, and its compare mask is set by the code: 0 none (invalid, mask 0x00000000), 1 small (0xFFFFF000), 2 large (0xFFFF0000), 3 section (0xFFF00000), 4 extended small (0xFFFFF000) and 5 tiny (0xFFFFFC00). Codes 6 and 7 are treated as invalid.
- R3: A lookup ignores invalid slots. It hits on a slot when (va & mask) equals (tag & mask), using that slot's mask. On a hit it outputs the slot's index, kind, physical base, permission field and domain. On a miss, hit is 0 and all the other lookup outputs are 0.
- R4: A fill stores the virtual and physical addresses ANDed with the mask of the kind being filled.
- R5: When several slots match, the lowest-indexed one is returned.
- R6: A fill writes the slot named by the replacement pointer. The pointer then advances by one and wraps from N_ENTRIES-1 to 0.
- R7: Flush-all marks every slot invalid and sets the pointer to 0.
- R8: Flush-by-address invalidates only the lowest-indexed slot that matches its address. If no slot matches, nothing changes.
- R9: When flush-all or flush-by-address is asserted in the same cycle as a fill, the fill is discarded and the pointer does not move.
- R10: The lookup outputs depend combinationally on the lookup address and the stored slots. Fills and flushes take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a valid matching slot |
| lk_idx | output | IDX_W | Index of the returned slot |
| lk_kind | output | 3 | Mapping kind of the returned slot |
| lk_pbase | output | 32 | Masked physical base of the returned slot |
| lk_perm | output | 12 | Permission field of the returned slot |
| lk_dom | output | 4 | Domain of the returned slot |
| fill_en | input | 1 | Write a new translation |
| fill_kind | input | 3 | Mapping kind of the new translation |
| fill_va | input | 32 | Virtual address of the new translation |
| fill_pa | input | 32 | Physical address of the new translation |
| fill_perm | input | 12 | Permission field of the new translation |
| fill_dom | input | 4 | Domain of the new translation |
| flush_all | input | 1 | Invalidate every slot and rewind the pointer |
| flush_one | input | 1 | Invalidate the slot matching flush_va |
| flush_va | input | 32 | Address for flush-by-address |

## Verification
Several properties are checked on every cycle. Each valid slot must hold a tag and base with no bits outside its mask. Every hit must point at a valid slot with no matching slot below it. The pointer must rewind after flush-all, advance with wrap on an accepted fill, and stay still otherwise. The slot named by a flush-by-address must read as invalid afterwards. Other behaviour shows up only in the bench's scenarios: the exact mask of each kind, overlapping entries of different kinds resolving to the lower index, the physical base and attributes that are returned, a flush that matches nothing leaving all lookups unchanged, and a fill discarded under a simultaneous flush.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int ADDR_W = 32;
    localparam int PERM_W = 12;
    localparam int DOM_W  = 4;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE    = 3'd0,
        KIND_SMALL   = 3'd1,
        KIND_LARGE   = 3'd2,
        KIND_SECTION = 3'd3,
        KIND_XSMALL  = 3'd4,
        KIND_TINY    = 3'd5
    } map_kind_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] vtag;
        logic [ADDR_W-1:0] pbase;
        logic [PERM_W-1:0] perm;
        logic [DOM_W-1:0]  dom;
    } xlt_entry_t;

    // Compare mask for each mapping kind; unknown codes give no mask.
    function automatic logic [ADDR_W-1:0] kind_mask(input logic [KIND_W-1:0] k);
        case (k)
            KIND_SMALL:   kind_mask = 32'hFFFF_F000;
            KIND_LARGE:   kind_mask = 32'hFFFF_0000;
            KIND_SECTION: kind_mask = 32'hFFF0_0000;
            KIND_XSMALL:  kind_mask = 32'hFFFF_F000;
            KIND_TINY:    kind_mask = 32'hFFFF_FC00;
            default:      kind_mask = 32'h0000_0000;
        endcase
    endfunction

    // A slot takes part in compares only with a known, non-empty kind.
    function automatic logic kind_live(input logic [KIND_W-1:0] k);
        kind_live = (k >= KIND_SMALL) && (k <= KIND_TINY);
    endfunction

endpackage

// File: rtl/xlt_match.sv
module xlt_match
    import xlt_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             va_i,
    input  xlt_entry_t [N_ENTRIES-1:0]    ents_i,
    output logic [N_ENTRIES-1:0]          match_o
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        logic [ADDR_W-1:0] msk;
        assign msk = kind_mask(ents_i[g].kind);
        assign match_o[g] = kind_live(ents_i[g].kind)
                         && ((va_i & msk) == (ents_i[g].vtag & msk));

        // R3: a slot that is not live never reports a match
        p_dead_no_match_r3: assert property (@(posedge clk) disable iff (rst)
            !kind_live(ents_i[g].kind) |-> !match_o[g]);
    end

endmodule

// File: rtl/xlt_prio.sv
module xlt_prio #(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_ENTRIES-1:0] match_i,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // R5: the chosen index matches and nothing below it does
    p_lowest_hit_r5: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (match_i[idx_o]
                   && ((match_i & ((N_ENTRIES'(1) << idx_o) - N_ENTRIES'(1))) == '0)));

    p_miss_no_match_r3: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (match_i == '0));

endmodule

// File: rtl/xlt_store.sv
module xlt_store
    import xlt_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fill_en_i,
    input  xlt_entry_t                  fill_ent_i,
    input  logic                        flush_all_i,
    input  logic                        flush_one_i,
    input  logic                        flush_hit_i,
    input  logic [IDX_W-1:0]            flush_idx_i,
    output xlt_entry_t [N_ENTRIES-1:0]  ents_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    xlt_entry_t [N_ENTRIES-1:0] ents_q;
    logic [IDX_W-1:0]           ptr_q;
    logic                       fill_ok;

    // Any flush request blocks a fill in the same cycle.
    assign fill_ok = fill_en_i && !flush_all_i && !flush_one_i;

    always_ff @(posedge clk) begin
        if (rst || flush_all_i) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                ents_q[i].kind <= KIND_NONE;
            end
            ptr_q <= '0;
        end else if (flush_one_i) begin
            if (flush_hit_i) begin
                ents_q[flush_idx_i].kind <= KIND_NONE;
            end
        end else if (fill_ok) begin
            ents_q[ptr_q] <= fill_ent_i;
            ptr_q         <= (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
        end
    end

    assign ents_o = ents_q;

    // R7: flush-all rewinds the pointer and empties slot 0
    p_flush_rewind_r7: assert property (@(posedge clk) disable iff (rst)
        flush_all_i |=> (ptr_q == '0) && (ents_q[0].kind == KIND_NONE));

    // R6: an accepted fill advances the pointer with wrap
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        fill_ok |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + IDX_W'(1)));

    // R9: without an accepted fill or flush-all the pointer holds
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!fill_ok && !flush_all_i) |=> $stable(ptr_q));

    // R8: the flushed slot reads as invalid on the next cycle
    p_flush_one_r8: assert property (@(posedge clk) disable iff (rst)
        (flush_one_i && flush_hit_i && !flush_all_i)
        |=> ents_q[$past(flush_idx_i)].kind == KIND_NONE);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
        // R4: live slots hold no bits outside their mask
        p_masked_r4: assert property (@(posedge clk) disable iff (rst)
            kind_live(ents_q[g].kind) |->
                (((ents_q[g].vtag | ents_q[g].pbase) & ~kind_mask(ents_q[g].kind)) == '0));
    end

endmodule

// File: rtl/xlt_cache.sv
module xlt_cache
    import xlt_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       lk_va,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [2:0]        lk_kind,
    output logic [31:0]       lk_pbase,
    output logic [11:0]       lk_perm,
    output logic [3:0]        lk_dom,
    input  logic              fill_en,
    input  logic [2:0]        fill_kind,
    input  logic [31:0]       fill_va,
    input  logic [31:0]       fill_pa,
    input  logic [11:0]       fill_perm,
    input  logic [3:0]        fill_dom,
    input  logic              flush_all,
    input  logic              flush_one,
    input  logic [31:0]       flush_va
);

    xlt_entry_t [N_ENTRIES-1:0] ents;
    xlt_entry_t                 fill_ent;
    xlt_entry_t                 sel;
    logic [N_ENTRIES-1:0]       lk_match;
    logic [N_ENTRIES-1:0]       fl_match;
    logic                       hit_w;
    logic [IDX_W-1:0]           idx_w;
    logic                       fl_hit;
    logic [IDX_W-1:0]           fl_idx;
    logic [ADDR_W-1:0]          fmask;

    assign fmask          = kind_mask(fill_kind);
    assign fill_ent.kind  = fill_kind;
    assign fill_ent.vtag  = fill_va & fmask;
    assign fill_ent.pbase = fill_pa & fmask;
    assign fill_ent.perm  = fill_perm;
    assign fill_ent.dom   = fill_dom;

    xlt_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .fill_en_i   (fill_en),
        .fill_ent_i  (fill_ent),
        .flush_all_i (flush_all),
        .flush_one_i (flush_one),
        .flush_hit_i (fl_hit),
        .flush_idx_i (fl_idx),
        .ents_o      (ents)
    );

    // Two compare paths: one for lookup, one for flush-by-address.
    xlt_match #(.N_ENTRIES(N_ENTRIES)) u_lk_match (
        .clk (clk), .rst (rst), .va_i (lk_va), .ents_i (ents), .match_o (lk_match)
    );
    xlt_prio #(.N_ENTRIES(N_ENTRIES)) u_lk_prio (
        .clk (clk), .rst (rst), .match_i (lk_match), .hit_o (hit_w), .idx_o (idx_w)
    );
    xlt_match #(.N_ENTRIES(N_ENTRIES)) u_fl_match (
        .clk (clk), .rst (rst), .va_i (flush_va), .ents_i (ents), .match_o (fl_match)
    );
    xlt_prio #(.N_ENTRIES(N_ENTRIES)) u_fl_prio (
        .clk (clk), .rst (rst), .match_i (fl_match), .hit_o (fl_hit), .idx_o (fl_idx)
    );

    always_comb begin
        sel = '0;
        if (hit_w) begin
            sel = ents[idx_w];
        end
    end

    assign lk_hit   = hit_w;
    assign lk_idx   = hit_w ? idx_w : '0;
    assign lk_kind  = sel.kind;
    assign lk_pbase = sel.pbase;
    assign lk_perm  = sel.perm;
    assign lk_dom   = sel.dom;

    // R3: a hit returns a live kind, a miss returns cleared fields
    p_hit_live_r3: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> kind_live(lk_kind));
    p_miss_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_kind == 3'd0 && lk_pbase == '0 && lk_dom == '0 && lk_perm == '0));

endmodule

// File: tb/xlt_cache_tb.sv
module xlt_cache_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_va;
    logic        lk_hit;
    logic [2:0]  lk_idx;
    logic [2:0]  lk_kind;
    logic [31:0] lk_pbase;
    logic [11:0] lk_perm;
    logic [3:0]  lk_dom;
    logic        fill_en;
    logic [2:0]  fill_kind;
    logic [31:0] fill_va, fill_pa;
    logic [11:0] fill_perm;
    logic [3:0]  fill_dom;
    logic        flush_all, flush_one;
    logic [31:0] flush_va;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlt_cache #(.N_ENTRIES(N)) dut_i (
        .clk (clk), .rst (rst), .lk_va (lk_va), .lk_hit (lk_hit), .lk_idx (lk_idx),
        .lk_kind (lk_kind), .lk_pbase (lk_pbase), .lk_perm (lk_perm), .lk_dom (lk_dom),
        .fill_en (fill_en), .fill_kind (fill_kind), .fill_va (fill_va), .fill_pa (fill_pa),
        .fill_perm (fill_perm), .fill_dom (fill_dom), .flush_all (flush_all),
        .flush_one (flush_one), .flush_va (flush_va)
    );

    // Fill table: kinds 1 small, 2 large, 3 section, 4 ext small, 5 tiny (R2)
    localparam logic [2:0]  F_KIND [N] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd3, 3'd1, 3'd5};
    localparam logic [31:0] F_VA   [N] = '{32'h1234_5678, 32'h2000_ABCD, 32'h3FF1_2345, 32'h4000_1FFF,
                                           32'h5000_07FF, 32'h1230_0000, 32'h2000_1000, 32'h6000_0C00};
    localparam logic [31:0] F_PA   [N] = '{32'hAAAA_BFFF, 32'h5555_7777, 32'h8011_1111, 32'h0000_2ABC,
                                           32'h1234_5FFF, 32'h9000_0000, 32'hCCCC_C000, 32'h7000_0400};

    // Lookup vectors: address, expected hit, index, masked base
    localparam int NV = 11;
    localparam logic [31:0] V_VA  [NV] = '{32'h1234_5FFF, 32'h1239_9999, 32'h2000_F000, 32'h2000_1004,
                                           32'h3FFF_FFFF, 32'h4000_1000, 32'h4000_2000, 32'h5000_04FF,
                                           32'h5000_0800, 32'h6000_0FFF, 32'h0000_0000};
    localparam logic        V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [2:0]  V_IDX [NV] = '{3'd0, 3'd5, 3'd1, 3'd1, 3'd2, 3'd3, 3'd0, 3'd4, 3'd0, 3'd7, 3'd0};
    localparam logic [31:0] V_PB  [NV] = '{32'hAAAA_B000, 32'h9000_0000, 32'h5555_0000, 32'h5555_0000,
                                           32'h8010_0000, 32'h0000_2000, 32'h0, 32'h1234_5C00,
                                           32'h0, 32'h7000_0400, 32'h0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic hit,
                        input logic [2:0] idx, input logic [31:0] pb);
        @(negedge clk);
        lk_va = va;
        #1;
        chk(req, {31'd0, lk_hit}, {31'd0, hit});
        chk(req, {29'd0, lk_idx}, {29'd0, idx});
        chk(req, lk_pbase, pb);
    endtask

    task automatic do_fill(input logic [2:0] k, input logic [31:0] va, input logic [31:0] pa,
                           input logic [3:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_kind = k; fill_va = va; fill_pa = pa;
        fill_perm = {d, d, d}; fill_dom = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_flush_one(input logic [31:0] va);
        @(negedge clk);
        flush_one = 1'b1; flush_va = va;
        @(negedge clk);
        flush_one = 1'b0;
    endtask

    initial begin
        rst = 1'b1; lk_va = '0; fill_en = 1'b0; fill_kind = '0; fill_va = '0; fill_pa = '0;
        fill_perm = '0; fill_dom = '0; flush_all = 1'b0; flush_one = 1'b0; flush_va = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        look("R1", 32'h1234_5678, 1'b0, 3'd0, 32'h0);
        chk("R3 miss fields", {17'd0, lk_kind, lk_perm}, 32'h0);

        for (int i = 0; i < N; i++) begin
            do_fill(F_KIND[i], F_VA[i], F_PA[i], 4'(i + 1));
        end
        // R1: first fill landed in slot 0
        look("R1 first slot", 32'h1234_5000, 1'b1, 3'd0, 32'hAAAA_B000);

        // R2 R3 R4 R5: vector walk
        for (int v = 0; v < NV; v++) begin
            look("R2/R3/R4/R5 vector", V_VA[v], V_HIT[v], V_IDX[v], V_PB[v]);
        end

        // R3: attributes of slot 4 (tiny, domain 5)
        look("R3", 32'h5000_0400, 1'b1, 3'd4, 32'h1234_5C00);
        chk("R3 kind", {29'd0, lk_kind}, 32'd5);
        chk("R3 domain", {28'd0, lk_dom}, 32'd5);
        chk("R3 perm", {20'd0, lk_perm}, 32'h555);

        // R6: pointer wrapped, ninth fill replaces slot 0
        do_fill(3'd1, 32'h7000_0123, 32'h0BAD_0FFF, 4'd9);
        look("R6 wrap", 32'h7000_0000, 1'b1, 3'd0, 32'h0BAD_0000);
        look("R6 replaced", 32'h1234_5678, 1'b1, 3'd5, 32'h9000_0000);

        // R8: flush the lower of two overlapping matches
        do_flush_one(32'h2000_1004);
        look("R8 lower dropped", 32'h2000_1004, 1'b1, 3'd6, 32'hCCCC_C000);
        look("R8 gone", 32'h2000_F000, 1'b0, 3'd0, 32'h0);
        // R8: no match leaves everything alone
        do_flush_one(32'h0000_0000);
        look("R8 untouched", 32'h3FFF_FFFF, 1'b1, 3'd2, 32'h8010_0000);
        look("R8 untouched", 32'h6000_0FFF, 1'b1, 3'd7, 32'h7000_0400);

        // R9: fill with simultaneous flush is dropped, pointer stays at 1
        @(negedge clk);
        fill_en = 1'b1; fill_kind = 3'd1; fill_va = 32'h7100_0000; fill_pa = 32'h1;
        flush_one = 1'b1; flush_va = 32'h0000_0000;
        @(negedge clk);
        fill_en = 1'b0; flush_one = 1'b0;
        look("R9 dropped", 32'h7100_0000, 1'b0, 3'd0, 32'h0);
        do_fill(3'd1, 32'h7200_0000, 32'h2200_0000, 4'd3);
        look("R9 pointer held", 32'h7200_0000, 1'b1, 3'd1, 32'h2200_0000);

        // R7: flush-all empties and rewinds
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        look("R7 empty", 32'h3FFF_FFFF, 1'b0, 3'd0, 32'h0);
        look("R7 empty", 32'h7000_0000, 1'b0, 3'd0, 32'h0);
        do_fill(3'd3, 32'hABCD_EF01, 32'h1357_9BDF, 4'd2);
        look("R7 rewound", 32'hABC0_0000, 1'b1, 3'd0, 32'h1350_0000);

        // R10: same-cycle lookup response on an address change
        @(negedge clk);
        lk_va = 32'hABCF_FFFF;
        #1 chk("R10", {31'd0, lk_hit}, 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule